// File: doc/BRIEF.md
# DMA Channel Programming Sequencer

This block turns one transfer request into the series of byte-wide register writes that set up a channel on a legacy pair of cascaded four-channel DMA controllers and their page registers. A request carries a channel number, a 24-bit physical address, a byte count and a three-bit mode. The block first checks the request. It then holds the channel masked while it programs the transfer and releases the mask as its final step.

Channels 0 to 3 belong to the byte controller and channels 4 to 7 to the word controller. On the word controller the address and the count are given in 16-bit words, and its register offsets are spaced twice as far apart. The output is a plain write port: a target select, an offset, a data byte and a strobe, with one write per clock. Done and error pulses report the result. The block also keeps the requested length for each channel, plus a per-channel finished flag that an external terminal-count report sets.

Top module: `dma_prog_seq`

## Requirements
- R1: Channel bit 2 picks the target. Writes for channels 0-3 use wr_sel 0 (byte controller) and writes for channels 4-7 use wr_sel 1 (word controller). Channel bits [1:0] give the local channel c. Page writes use wr_sel 2.
- R2: The page write goes to offset 0x7, 0x3, 0x1 or 0x2 for local channel 0-3 of the byte controller, and to 0xF, 0xB, 0x9 or 0xA for the word controller. Its data is address bits [23:16], taken before any shift.
- R3: An accepted request produces exactly nine writes, in this order: mask set, flip-flop clear, mode, page, address low, address high, count low, count high, mask clear. On the byte controller the offsets are 0x0A (mask), 0x0C (flip-flop clear, data 0), 0x0B (mode), 2c (address) and 2c+1 (count). On the word controller each of these offsets is doubled.
- R4: The mode byte is c in bits [1:0]. Bit 2 is set when mode[0]=0 (write, device to memory). Bit 3 is set when mode[0]=1 (read, memory to device). Bit 4 copies mode[2] (auto-initialize). Bit 6 is set when mode[1]=0 (single), and a demand transfer (mode[1]=1) leaves bits 7:6 at 0.
- R5: Byte channels write address bits [7:0] and then [15:8]. Word channels write the address shifted right by one, low byte first.
- R6: The count is written as (length − 1) on byte channels and as (length/2 − 1) on word channels, low byte first, modulo 2^16.
- R7: A byte-channel request longer than 65536 is rejected. A word-channel request is rejected if it is longer than 131072, or if its length or its address is odd.
- R8: A request for a channel index above 7, or for a channel whose alloc_mask bit is 0, is rejected.
- R9: A rejected request raises err for one cycle, issues no write and leaves busy low.
- R10: busy is high in exactly the nine cycles that carry a write, and wr_en matches busy. done pulses for one cycle right after the final unmask write.
- R11: A request that arrives while busy is high is ignored. The running sequence goes on unchanged and no second sequence follows it.
- R12: An accepted request records its byte length, which can be read back on len_q for the channel chosen by len_sel. It also clears that channel's finished flag in the same cycle. A rejected request changes neither.
- R13: fin_set bits are ORed into fin_flags. When a set and a start clear hit the same bit in the same cycle, the clear wins.
- R14: The mask-set write carries data c|0x04 and the mask-clear write carries data c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request strobe |
| req_chan | input | 4 | Requested channel index (0-15, valid 0-7) |
| req_addr | input | AW | Physical start address |
| req_len | input | LW | Transfer length in bytes |
| req_mode | input | 3 | bit0 read(1)/write(0), bit1 demand, bit2 auto-initialize |
| alloc_mask | input | 8 | Per-channel allocated flags |
| fin_set | input | 8 | Terminal-count reports, one bit per channel |
| len_sel | input | 3 | Channel whose recorded length is shown on len_q |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last write |
| err | output | 1 | One-cycle pulse on a rejected request |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 2 | 0 byte controller, 1 word controller, 2 page registers |
| wr_ofs | output | 5 | Register offset within the target |
| wr_data | output | 8 | Write data |
| fin_flags | output | 8 | Per-channel finished flags |
| len_q | output | LW | Recorded length for channel len_sel |

## Verification
The stimulus covers byte and word channels with distinct local channel numbers, so the page-table lookup and the offset doubling are checked separately for each controller. It uses all four direction/transfer combinations, with and without the loop bit. Addresses with different bytes in every position show whether the page byte comes from the unshifted address while the address bytes come from the shifted one. Lengths at exactly 65536 and 131072 confirm the count wraps to 0xFFFF. Lengths just past those limits, odd values and bad channels show that rejection happens before any write. A mid-sequence request and a set/clear collision on the finished flags test the ordering rules.

// File: rtl/dma_prog_seq.sv
module dma_prog_seq #(
  parameter int AW = 24,
  parameter int LW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_chan,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [2:0]    req_mode,
  input  logic [7:0]    alloc_mask,
  input  logic [7:0]    fin_set,
  input  logic [2:0]    len_sel,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          wr_en,
  output logic [1:0]    wr_sel,
  output logic [4:0]    wr_ofs,
  output logic [7:0]    wr_data,
  output logic [7:0]    fin_flags,
  output logic [LW-1:0] len_q
);
  localparam int NCH = 8;
  localparam int LAST = 8;
  localparam logic [LW-1:0] BYTE_MAX = LW'(65536);
  localparam logic [LW-1:0] WORD_MAX = LW'(131072);
  localparam logic [3:0] R_MASK = 4'hA;
  localparam logic [3:0] R_MODE = 4'hB;
  localparam logic [3:0] R_FFC  = 4'hC;

  logic          busy_q, done_q, err_q;
  logic [3:0]    step_q;
  logic [2:0]    ch_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_r;
  logic [2:0]    mode_q;
  logic [7:0]    fin_q;
  logic [LW-1:0] len_mem [NCH];

  wire accept   = req_valid && !busy_q;
  wire in_range = !req_chan[3];
  wire rq_word  = req_chan[2];
  wire rq_alloc = alloc_mask[req_chan[2:0]];
  wire len_ok   = rq_word ? (req_len <= WORD_MAX) && !req_len[0] && !req_addr[0]
                          : (req_len <= BYTE_MAX);
  wire rq_good  = in_range && rq_alloc && len_ok;
  wire start    = accept && rq_good;
  wire [7:0] clr_bit = start ? (8'b1 << req_chan[2:0]) : 8'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      step_q <= '0;
      ch_q   <= '0;
      addr_q <= '0;
      len_r  <= '0;
      mode_q <= '0;
      fin_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      fin_q  <= (fin_q | fin_set) & ~clr_bit;
      if (accept) begin
        if (rq_good) begin
          busy_q <= 1'b1;
          step_q <= '0;
          ch_q   <= req_chan[2:0];
          addr_q <= req_addr;
          len_r  <= req_len;
          mode_q <= req_mode;
        end else begin
          err_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (step_q == 4'(LAST)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) len_mem[i] <= '0;
    end else if (start) begin
      len_mem[req_chan[2:0]] <= req_len;
    end
  end

  wire           word   = ch_q[2];
  wire [1:0]     lc     = ch_q[1:0];
  wire [AW-1:0]  a_eff  = word ? (addr_q >> 1) : addr_q;
  wire [LW-1:0]  n_eff  = word ? (len_r >> 1) : len_r;
  wire [15:0]    cnt    = n_eff[15:0] - 16'd1;
  wire [7:0]     md     = {1'b0, ~mode_q[1], 1'b0, mode_q[2], mode_q[0], ~mode_q[0], lc};

  logic [3:0] pg_ofs;
  always_comb begin
    case (lc)
      2'd0:    pg_ofs = 4'h7;
      2'd1:    pg_ofs = 4'h3;
      2'd2:    pg_ofs = 4'h1;
      default: pg_ofs = 4'h2;
    endcase
    if (word) pg_ofs = pg_ofs | 4'h8;
  end

  logic [3:0] base;
  logic       to_page;
  always_comb begin
    base    = R_MASK;
    to_page = 1'b0;
    wr_data = 8'h00;
    case (step_q)
      4'd0: begin base = R_MASK; wr_data = {5'b0, 1'b1, lc}; end
      4'd1: begin base = R_FFC;  wr_data = 8'h00; end
      4'd2: begin base = R_MODE; wr_data = md; end
      4'd3: begin to_page = 1'b1; wr_data = addr_q[23:16]; end
      4'd4: begin base = {1'b0, lc, 1'b0}; wr_data = a_eff[7:0]; end
      4'd5: begin base = {1'b0, lc, 1'b0}; wr_data = a_eff[15:8]; end
      4'd6: begin base = {1'b0, lc, 1'b1}; wr_data = cnt[7:0]; end
      4'd7: begin base = {1'b0, lc, 1'b1}; wr_data = cnt[15:8]; end
      default: begin base = R_MASK; wr_data = {5'b0, 1'b0, lc}; end
    endcase
  end

  assign wr_sel    = to_page ? 2'd2 : {1'b0, word};
  assign wr_ofs    = to_page ? {1'b0, pg_ofs} : (word ? {base, 1'b0} : {1'b0, base});
  assign wr_en     = busy_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign fin_flags = fin_q;
  assign len_q     = len_mem[len_sel];

  a_r9_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_en && !busy);
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r14_first_is_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_data[2] && (wr_sel != 2'd2));
  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ch_q) && $stable(addr_q) && $stable(len_r));
  a_r12_fin_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !fin_flags[$past(req_chan[2:0])]);
endmodule

// File: tb/dma_prog_seq_tb.sv
module dma_prog_seq_tb_top;
  localparam int CLK_NS = 10;
  localparam int NV = 12;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [3:0] req_chan = 0;
  logic [23:0] req_addr = 0;
  logic [17:0] req_len = 0;
  logic [2:0] req_mode = 0;
  logic [7:0] alloc_mask = 8'hF7;
  logic [7:0] fin_set = 0;
  logic [2:0] len_sel = 0;
  logic busy, done, err, wr_en;
  logic [1:0] wr_sel;
  logic [4:0] wr_ofs;
  logic [7:0] wr_data, fin_flags;
  logic [17:0] len_q;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  dma_prog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_addr(req_addr), .req_len(req_len), .req_mode(req_mode),
    .alloc_mask(alloc_mask), .fin_set(fin_set), .len_sel(len_sel),
    .busy(busy), .done(done), .err(err), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_ofs(wr_ofs), .wr_data(wr_data), .fin_flags(fin_flags), .len_q(len_q));

  // {chan, addr, len, mode, expect_reject}
  localparam logic [49:0] VEC [NV] = '{
    {4'd0, 24'h123456, 18'h00100, 3'd0, 1'b0},
    {4'd1, 24'hABCDEF, 18'h10000, 3'd1, 1'b0},
    {4'd2, 24'h000010, 18'h10001, 3'd0, 1'b1},
    {4'd3, 24'h000020, 18'h00010, 3'd0, 1'b1},
    {4'd5, 24'h02468A, 18'h00400, 3'd3, 1'b0},
    {4'd6, 24'h000101, 18'h00010, 3'd0, 1'b1},
    {4'd7, 24'h000100, 18'h00011, 3'd0, 1'b1},
    {4'd4, 24'h8ACE00, 18'h20000, 3'd7, 1'b0},
    {4'd4, 24'h000000, 18'h20002, 3'd0, 1'b1},
    {4'd9, 24'h000000, 18'h00010, 3'd0, 1'b1},
    {4'd2, 24'h5A7B3C, 18'h00001, 3'd6, 1'b0},
    {4'd7, 24'hFFFFFE, 18'h00002, 3'd5, 1'b0}
  };

  function automatic logic [14:0] expw(input logic [3:0] ch, input logic [23:0] a,
                                       input logic [17:0] n, input logic [2:0] m, input int k);
    logic w; logic [1:0] c; logic [23:0] ae; logic [15:0] ce;
    logic [3:0] pg; logic [7:0] md; logic [4:0] mul;
    w = ch[2]; c = ch[1:0];
    ae = w ? a >> 1 : a;
    ce = (w ? 16'(n >> 1) : n[15:0]) - 16'd1;
    case (c) 2'd0: pg = 4'h7; 2'd1: pg = 4'h3; 2'd2: pg = 4'h1; default: pg = 4'h2; endcase
    if (w) pg = pg + 4'h8;
    md = {6'b0, c} | (m[0] ? 8'h08 : 8'h04) | (m[2] ? 8'h10 : 8'h00) | (m[1] ? 8'h00 : 8'h40);
    mul = w ? 5'd2 : 5'd1;
    case (k)
      0: return {1'b0, w, 5'(5'h0A * mul), {6'b0, c} | 8'h04};
      1: return {1'b0, w, 5'(5'h0C * mul), 8'h00};
      2: return {1'b0, w, 5'(5'h0B * mul), md};
      3: return {2'd2, {1'b0, pg}, a[23:16]};
      4: return {1'b0, w, 5'({3'b0, c, 1'b0} * mul), ae[7:0]};
      5: return {1'b0, w, 5'({3'b0, c, 1'b0} * mul), ae[15:8]};
      6: return {1'b0, w, 5'({3'b0, c, 1'b1} * mul), ce[7:0]};
      7: return {1'b0, w, 5'({3'b0, c, 1'b1} * mul), ce[15:8]};
      default: return {1'b0, w, 5'(5'h0A * mul), {6'b0, c}};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R10 R14: write stream; R7 R8 R9: rejection
  task automatic apply(input logic [3:0] ch, input logic [23:0] a, input logic [17:0] n,
                       input logic [2:0] m, input bit rej, input bit poke);
    @(negedge clk);
    req_chan = ch; req_addr = a; req_len = n; req_mode = m; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (rej) begin
      chk(err && !wr_en && !busy, "R7/R8/R9 reject", {err, wr_en, busy}, 3'b100);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(!wr_en && !busy && !err, "R9 no writes", {wr_en, busy, err}, 0);
      end
    end else begin
      for (int k = 0; k < 9; k++) begin
        logic [14:0] e;
        e = expw(ch, a, n, m, k);
        chk(wr_en && busy && {wr_sel, wr_ofs, wr_data} == e, "R1/R2/R3/R4/R5/R6/R14 write",
            {wr_en, busy, wr_sel, wr_ofs, wr_data}, {2'b11, e});
        if (poke && k == 1) begin
          req_chan = 4'd1; req_addr = 24'h777777; req_len = 18'h40; req_valid = 1;
        end else req_valid = 0;
        @(negedge clk);
      end
      req_valid = 0;
      chk(done && !busy && !wr_en, "R10 done pulse", {done, busy, wr_en}, 3'b100);
      @(negedge clk);
      chk(!done && !wr_en, "R11 no second sequence", {done, wr_en}, 0);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !wr_en && !done && !err && fin_flags == 0, "reset state",
        {busy, wr_en, done, err, fin_flags}, 0);

    for (int v = 0; v < NV; v++)
      apply(VEC[v][49:46], VEC[v][45:22], VEC[v][21:4], VEC[v][3:1], VEC[v][0], 1'b0);

    // R11: request during busy is dropped
    apply(4'd0, 24'h00FF00, 18'h00080, 3'd2, 1'b0, 1'b1);

    // R13 and R12: set flags, then a start clears its own bit
    @(negedge clk); fin_set = 8'hFF;
    @(negedge clk); fin_set = 8'h00;
    chk(fin_flags == 8'hFF, "R13 fin set", fin_flags, 8'hFF);
    apply(4'd5, 24'h001000, 18'h00400, 3'd0, 1'b0, 1'b0);
    chk(fin_flags == 8'hDF, "R12 start clears flag", fin_flags, 8'hDF);
    len_sel = 3'd5; #1;
    chk(len_q == 18'h00400, "R12 length recorded", len_q, 18'h400);
    len_sel = 3'd4; #1;
    chk(len_q == 18'h20000, "R12 length ch4", len_q, 18'h20000);

    // R12: rejected request on ch6 leaves flag and length alone
    apply(4'd6, 24'h000001, 18'h00010, 3'd0, 1'b1, 1'b0);
    len_sel = 3'd6; #1;
    chk(fin_flags[6] && len_q == 0, "R12 reject keeps state", {fin_flags[6], len_q}, {1'b1, 18'h0});

    // R13: clear wins over set in the same cycle
    @(negedge clk);
    req_chan = 4'd2; req_addr = 24'h0; req_len = 18'h8; req_mode = 0; req_valid = 1; fin_set = 8'h04;
    @(negedge clk);
    req_valid = 0; fin_set = 0;
    chk(!fin_flags[2], "R13 clear beats set", fin_flags[2], 0);
    repeat (12) @(negedge clk);
    chk(!busy, "R10 idle after sequence", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule